// File: doc/BRIEF.md
# Way-Lockable Four-Way Cache with Scratch-RAM Window

This block holds the tag and data storage of a four-way set-associative cache with one data word per line. A read port looks a word up in all four ways. On a miss the word is fetched from a backing memory and, if a way is free to take it, allocated there. A four-bit mask, `way_en`, decides which ways take part in replacement. A way left out of the mask is never chosen as a victim, but it still answers hits. Software can therefore fill a way with chosen lines, take the way out of the mask, and keep those lines resident whatever other traffic runs.

A second port, the management window, reaches any way and set directly, with no tag compare. Ways that are out of the mask can then serve as plain scratch RAM. The window is cut into one bank per way, and the banks lie next to each other in address order. A write through the window marks the line valid and dirty, and it writes a tag built from the window address. Four alias bits of that address choose nothing in the storage, but they end up in the tag. A half-size build backs only the lower half of each bank.

The backing memory is modelled as a single-cycle device. `mem_rdata` must be valid combinationally while `mem_req` is high and `mem_we` is low, and a write is taken at the clock edge that ends the request cycle. `way_en` must stay stable while a miss is open.

Top module: `wayram_cache`

## Requirements
- R1: After reset all lines are invalid, `rd_valid`, `mg_ack` and `mem_req` are low, and the first read of any address is a miss.
- R2: A read is accepted at a clock edge where `rd_req` is high, the block is idle and `rd_valid` is low. On a hit, `rd_valid` is high for exactly one cycle after that edge, with `rd_hit`=1 and the stored word on `rd_data`. The requester holds `rd_req` until it sees `rd_valid`.
- R3: On a miss with at least one way enabled, the victim is the first enabled way found by searching cyclically from a pointer. After the allocation the pointer moves to the way after that victim. A clean miss returns the memory word with `rd_hit`=0 two cycles after acceptance, and the word is installed clean in the victim way.
- R4: A way whose `way_en` bit is 0 is never written by a fill, yet its valid lines still hit. Lines loaded into it stay resident under any amount of conflicting traffic.
- R5: With `way_en`=0 a miss is served from memory with `rd_hit`=0, and nothing is allocated. A repeated read of the same address misses again.
- R6: When the victim line is valid and dirty, the block first writes it to memory at address {tag, set} for one cycle and then fills. The read returns three cycles after acceptance.
- R7: A management address is laid out as {alias[3:0], way[1:0], slot[IDX_W-1:0]}, with the slot as the least significant field. Way n's bank therefore starts at n×2^IDX_W, and consecutive ways form one contiguous RAM.
- R8: A management write stores `mg_wdata` at the chosen way and slot and marks the line valid and dirty. The line's tag becomes {alias, way}, zero-extended. A management read returns the stored word. The alias bits never change which location is reached. `mg_ack` pulses for one cycle after acceptance.
- R9: With HALF=1, a management address whose top slot bit is set reaches no storage. A write to it is dropped, and a read of it returns 0.
- R10: A read and a management request raised in the same cycle are ordered read first. The management acknowledge comes one cycle later than it would alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| way_en | input | 4 | Ways allowed to take new lines |
| rd_req | input | 1 | Read request, held until `rd_valid` |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_valid | output | 1 | Read response strobe |
| rd_hit | output | 1 | Response came from a resident line |
| rd_data | output | DATA_W | Read data |
| mg_req | input | 1 | Management request, held until `mg_ack` |
| mg_we | input | 1 | Management write when 1, read when 0 |
| mg_addr | input | IDX_W+6 | Window address {alias, way, slot} |
| mg_wdata | input | DATA_W | Management write data |
| mg_ack | output | 1 | Management completion strobe |
| mg_rdata | output | DATA_W | Management read data |
| mem_req | output | 1 | Backing memory access |
| mem_we | output | 1 | Backing memory write (write-back) |
| mem_addr | output | ADDR_W | Backing memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Fill data, valid in the request cycle |

## Verification
The bench sweeps every set with more tags than ways and follows the cache with its own model of the round-robin pointer. A victim choice that picked a disabled way, or that failed to skip one, shows up later as a wrong hit flag. The main lock scenario fills a single way, takes it out of the mask, and floods the other ways. A design that let the mask gate lookup would lose the hits, and one that let it miss allocation would evict the locked lines. Other passes cover the following: window writes over all 64 locations, read back through different alias bits to expose a misplaced field or a non-contiguous bank; a window line that a normal read then hits and whose dirty eviction must reach memory at the tag-derived address; an all-disabled mask that must not allocate; a same-cycle collision that must delay the management acknowledge; and the unbacked upper half of the half-size build.

// File: rtl/wrc_pkg.sv
// Shared constants and types for the way-lockable cache.
// Assumes exactly four ways; the window alias field is four bits wide.
package wrc_pkg;
    localparam int NWAYS   = 4;
    localparam int WAY_W   = 2;
    localparam int ALIAS_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WB   = 2'd1,
        ST_FILL = 2'd2
    } wrc_state_e;
endpackage

// File: rtl/wrc_way_store.sv
// One way of the cache: valid/dirty bits, tags and data words per set.
// One write port; port A (lookup / write-back) and port B (window read) are
// combinational reads. Assumes the caller never writes and reads the same
// set expecting the new value in the same cycle.
module wrc_way_store #(
    parameter int SET_W  = 4,
    parameter int TAG_W  = 7,
    parameter int DATA_W = 16,
    localparam int SETS  = 1 << SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_dirty,
    input  logic [SET_W-1:0]  a_idx,
    output logic              a_valid,
    output logic              a_dirty,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [SET_W-1:0]  b_idx,
    output logic [DATA_W-1:0] b_data
);
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // Line state bits: cleared by reset, set on any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    // Tag and data payload storage (no reset needed, guarded by valid).
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    // Read ports.
    always_comb begin
        a_valid = valid_q[a_idx];
        a_dirty = dirty_q[a_idx];
        a_tag   = tag_q[a_idx];
        a_data  = data_q[a_idx];
        b_data  = data_q[b_idx];
    end
endmodule

// File: rtl/wrc_hit_detect.sv
// Compares a lookup tag against all ways of one set.
// Assumes duplicate tags may exist (window writes can create them); the
// lowest-numbered matching way wins.
module wrc_hit_detect #(
    parameter int TAG_W = 7
) (
    input  logic [wrc_pkg::NWAYS-1:0]             valid,
    input  logic [wrc_pkg::NWAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]                      look_tag,
    output logic                                  hit,
    output logic [wrc_pkg::WAY_W-1:0]             hit_way
);
    import wrc_pkg::*;

    // Priority compare, scanned high to low so the lowest match is kept.
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (valid[w] && tags[w] == look_tag) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/wrc_victim_sel.sv
// Round-robin victim chooser that skips ways masked out of replacement.
// Assumes NWAYS is a power of two so pointer arithmetic wraps naturally.
module wrc_victim_sel (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [wrc_pkg::NWAYS-1:0]  way_en,
    input  logic                       advance,
    output logic [wrc_pkg::WAY_W-1:0]  victim,
    output logic                       any_en
);
    import wrc_pkg::*;

    logic [WAY_W-1:0] ptr_q;

    // Search from the pointer for the first enabled way.
    always_comb begin
        logic             found;
        logic [WAY_W-1:0] cand;
        found  = 1'b0;
        victim = ptr_q;
        for (int k = 0; k < NWAYS; k++) begin
            cand = ptr_q + WAY_W'(k);
            if (!found && way_en[cand]) begin
                victim = cand;
                found  = 1'b1;
            end
        end
        any_en = |way_en;
    end

    // Pointer moves past the way just allocated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= victim + WAY_W'(1);
        end
    end
endmodule

// File: rtl/wayram_cache.sv
// Four-way cache storage with a replacement mask and a direct window.
// Lookup always searches every way; the mask only limits allocation.
// The window reaches {way, slot} directly; writes mark lines valid+dirty and
// store {alias, way} as the tag. Assumes mem_rdata is combinational on
// mem_addr during a read request, and way_en is stable while a miss is open.
module wayram_cache #(
    parameter int ADDR_W = 11,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 16,
    parameter bit HALF   = 1'b0,
    localparam int SET_W = IDX_W - (HALF ? 1 : 0),
    localparam int TAG_W = ADDR_W - SET_W,
    localparam int MG_W  = wrc_pkg::ALIAS_W + wrc_pkg::WAY_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        way_en,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rd_data,
    input  logic              mg_req,
    input  logic              mg_we,
    input  logic [MG_W-1:0]   mg_addr,
    input  logic [DATA_W-1:0] mg_wdata,
    output logic              mg_ack,
    output logic [DATA_W-1:0] mg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import wrc_pkg::*;

    localparam int PAD_W = TAG_W - ALIAS_W - WAY_W;

    wrc_state_e state_q;

    logic [ADDR_W-1:0] lat_addr_q;
    logic [WAY_W-1:0]  lat_way_q;
    logic              lat_alloc_q;
    logic [SET_W-1:0]  lat_idx;
    logic [TAG_W-1:0]  lat_tag;

    logic [SET_W-1:0]  rd_idx;
    logic [TAG_W-1:0]  rd_tag;
    logic [IDX_W-1:0]  mg_slot;
    logic [WAY_W-1:0]  mg_way;
    logic [ALIAS_W-1:0] mg_alias;
    logic [SET_W-1:0]  mg_set;
    logic [TAG_W-1:0]  mg_tag;
    logic              mg_backed;

    logic              rd_acc, mg_acc, miss_go, advance, fill_now;
    logic              hit, any_en;
    logic [WAY_W-1:0]  hit_way, victim;
    logic [SET_W-1:0]  a_idx;

    logic [NWAYS-1:0]             a_valid, a_dirty, w_en;
    logic [NWAYS-1:0][TAG_W-1:0]  a_tag;
    logic [NWAYS-1:0][DATA_W-1:0] a_data, b_data;
    logic [SET_W-1:0]  wr_idx;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;
    logic              wr_dirty;

    // Split the read and window addresses into their fields.
    always_comb begin
        rd_idx   = rd_addr[SET_W-1:0];
        rd_tag   = rd_addr[ADDR_W-1:SET_W];
        lat_idx  = lat_addr_q[SET_W-1:0];
        lat_tag  = lat_addr_q[ADDR_W-1:SET_W];
        mg_slot  = mg_addr[IDX_W-1:0];
        mg_way   = mg_addr[IDX_W +: WAY_W];
        mg_alias = mg_addr[IDX_W+WAY_W +: ALIAS_W];
        mg_set   = mg_slot[SET_W-1:0];
        mg_tag   = {{PAD_W{1'b0}}, mg_alias, mg_way};
    end

    // Backing of the window slot depends on the size variant.
    generate
        if (HALF) begin : g_half
            assign mg_backed = ~mg_slot[IDX_W-1];
        end else begin : g_full
            assign mg_backed = 1'b1;
        end
    endgenerate

    // Request arbitration: reads first, window only when nothing else runs.
    always_comb begin
        rd_acc   = rd_req && state_q == ST_IDLE && !rd_valid;
        mg_acc   = mg_req && state_q == ST_IDLE && !rd_acc && !mg_ack;
        miss_go  = rd_acc && !hit;
        advance  = miss_go && any_en;
        fill_now = state_q == ST_FILL;
        a_idx    = (state_q == ST_IDLE) ? rd_idx : lat_idx;
    end

    // Shared write port fields: fill in FILL, window write otherwise.
    always_comb begin
        if (fill_now) begin
            wr_idx   = lat_idx;
            wr_tag   = lat_tag;
            wr_data  = mem_rdata;
            wr_dirty = 1'b0;
        end else begin
            wr_idx   = mg_set;
            wr_tag   = mg_tag;
            wr_data  = mg_wdata;
            wr_dirty = 1'b1;
        end
    end

    // One storage way per generate iteration.
    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        assign w_en[w] = (fill_now && lat_alloc_q && lat_way_q == WAY_W'(w)) ||
                         (mg_acc && mg_we && mg_backed && mg_way == WAY_W'(w));
        wrc_way_store #(
            .SET_W (SET_W),
            .TAG_W (TAG_W),
            .DATA_W(DATA_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (w_en[w]),
            .wr_idx  (wr_idx),
            .wr_tag  (wr_tag),
            .wr_data (wr_data),
            .wr_dirty(wr_dirty),
            .a_idx   (a_idx),
            .a_valid (a_valid[w]),
            .a_dirty (a_dirty[w]),
            .a_tag   (a_tag[w]),
            .a_data  (a_data[w]),
            .b_idx   (mg_set),
            .b_data  (b_data[w])
        );
    end

    wrc_hit_detect #(.TAG_W(TAG_W)) u_hit (
        .valid   (a_valid),
        .tags    (a_tag),
        .look_tag(rd_tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    wrc_victim_sel u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .way_en (way_en),
        .advance(advance),
        .victim (victim),
        .any_en (any_en)
    );

    // Backing memory request: write-back of the victim, then the fill.
    always_comb begin
        mem_req   = state_q != ST_IDLE;
        mem_we    = state_q == ST_WB;
        mem_addr  = (state_q == ST_WB) ? {a_tag[lat_way_q], lat_idx} : lat_addr_q;
        mem_wdata = a_data[lat_way_q];
    end

    // Miss sequencing and read response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            lat_addr_q  <= '0;
            lat_way_q   <= '0;
            lat_alloc_q <= 1'b0;
            rd_valid    <= 1'b0;
            rd_hit      <= 1'b0;
            rd_data     <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (rd_acc && hit) begin
                        rd_valid <= 1'b1;
                        rd_hit   <= 1'b1;
                        rd_data  <= a_data[hit_way];
                    end else if (miss_go) begin
                        lat_addr_q  <= rd_addr;
                        lat_way_q   <= victim;
                        lat_alloc_q <= any_en;
                        state_q     <= (any_en && a_valid[victim] && a_dirty[victim])
                                       ? ST_WB : ST_FILL;
                    end
                end
                ST_WB: begin
                    state_q <= ST_FILL;
                end
                ST_FILL: begin
                    rd_valid <= 1'b1;
                    rd_hit   <= 1'b0;
                    rd_data  <= mem_rdata;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Window response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mg_ack   <= 1'b0;
            mg_rdata <= '0;
        end else begin
            mg_ack <= mg_acc;
            if (mg_acc) begin
                mg_rdata <= mg_backed ? b_data[mg_way] : '0;
            end
        end
    end

    // R3 / R4: a fill only lands in a way the mask allows.
    p_fill_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && lat_alloc_q) |-> way_en[lat_way_q]);

    // R6: a write-back cycle is always followed by a fill read.
    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (mem_req && !mem_we));

    // R10: a window request losing to a read is not acknowledged next cycle.
    p_mgmt_yield_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && mg_req && !mg_ack) |=> !mg_ack);

    // R2: read response is a single-cycle strobe.
    p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R2 / R8: the two response strobes never coincide.
    p_resp_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && mg_ack));
endmodule

// File: tb/wayram_cache_bench.sv
// Self-checking bench: reference model of the cache state, backing memory
// model, and directed sweeps over all sets and all window locations.
module wayram_cache_bench;
    localparam int AW = 11;
    localparam int IW = 4;
    localparam int DW = 16;
    localparam int MW = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [3:0]    way_en = 4'hF;
    logic          rd_req = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_valid, rd_hit;
    logic [DW-1:0] rd_data;
    logic          mg_req = 1'b0, mg_we = 1'b0;
    logic [MW-1:0] mg_addr = '0;
    logic [DW-1:0] mg_wdata = '0;
    logic          mg_ack;
    logic [DW-1:0] mg_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic          h_req = 1'b0, h_we = 1'b0;
    logic [MW-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0;
    logic          h_ack, h_rvalid, h_hit, h_mreq, h_mwe;
    logic [DW-1:0] h_rdata, h_rd_data, h_mwdata;
    logic [AW-1:0] h_maddr;

    logic [DW-1:0] mem [1 << AW];
    logic [DW-1:0] ref_mem [1 << AW];

    int checks = 0;
    int errors = 0;

    function automatic logic [DW-1:0] seed(input int a);
        return DW'(a * 97 + 16'h03C1) ^ DW'(a << 7);
    endfunction

    assign mem_rdata = mem[mem_addr];

    // Backing memory: reloaded during reset, written by write-backs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < (1 << AW); a++) mem[a] <= seed(a);
        end else if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
    end

    wayram_cache u_wayram_cache (
        .clk(clk), .rst_n(rst_n), .way_en(way_en),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_hit(rd_hit), .rd_data(rd_data),
        .mg_req(mg_req), .mg_we(mg_we), .mg_addr(mg_addr),
        .mg_wdata(mg_wdata), .mg_ack(mg_ack), .mg_rdata(mg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    wayram_cache #(.HALF(1'b1)) u_wayram_cache_half (
        .clk(clk), .rst_n(rst_n), .way_en(4'h0),
        .rd_req(1'b0), .rd_addr('0), .rd_valid(h_rvalid),
        .rd_hit(h_hit), .rd_data(h_rd_data),
        .mg_req(h_req), .mg_we(h_we), .mg_addr(h_addr),
        .mg_wdata(h_wdata), .mg_ack(h_ack), .mg_rdata(h_rdata),
        .mem_req(h_mreq), .mem_we(h_mwe), .mem_addr(h_maddr),
        .mem_wdata(h_mwdata), .mem_rdata(16'h0000)
    );

    // Reference model of the cache contents.
    logic [6:0]    m_tag  [4][16];
    logic [DW-1:0] m_data [4][16];
    bit            m_v    [4][16];
    bit            m_d    [4][16];
    int            m_ptr = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one read, predict it from the model, check latency, hit and data.
    task automatic do_read(input int a, input string req);
        int idx, tg, hw, v, lat, n;
        logic [DW-1:0] ed;
        bit eh;
        idx = a % 16;
        tg  = a / 16;
        hw  = -1;
        for (int w = 3; w >= 0; w--)
            if (m_v[w][idx] && int'(m_tag[w][idx]) == tg) hw = w;
        if (hw >= 0) begin
            eh = 1'b1; ed = m_data[hw][idx]; lat = 1;
        end else begin
            eh = 1'b0; ed = ref_mem[a]; lat = 2;
            if (way_en != 4'h0) begin
                v = m_ptr;
                for (int k = 3; k >= 0; k--)
                    if (way_en[(m_ptr + k) % 4]) v = (m_ptr + k) % 4;
                if (m_v[v][idx] && m_d[v][idx]) begin
                    ref_mem[int'(m_tag[v][idx]) * 16 + idx] = m_data[v][idx];
                    lat = 3;
                end
                m_v[v][idx] = 1'b1; m_d[v][idx] = 1'b0;
                m_tag[v][idx] = 7'(tg); m_data[v][idx] = ed;
                m_ptr = (v + 1) % 4;
            end
        end
        @(negedge clk);
        rd_req = 1'b1; rd_addr = AW'(a);
        n = 0;
        do begin @(negedge clk); n++; end while (!rd_valid && n < 40);
        rd_req = 1'b0;
        chk(n == lat, {req, " latency"}, n, lat);
        chk(rd_hit == eh, {req, " hit"}, int'(rd_hit), int'(eh));
        chk(rd_data == ed, {req, " data"}, int'(rd_data), int'(ed));
    endtask

    // Window access on the full-size instance, model updated on writes.
    task automatic do_mg(input bit we, input int ma, input logic [DW-1:0] wd,
                         output logic [DW-1:0] rd, output int n);
        if (we) begin
            m_v[(ma / 16) % 4][ma % 16] = 1'b1;
            m_d[(ma / 16) % 4][ma % 16] = 1'b1;
            m_tag[(ma / 16) % 4][ma % 16] = 7'(ma / 16);
            m_data[(ma / 16) % 4][ma % 16] = wd;
        end
        @(negedge clk);
        mg_req = 1'b1; mg_we = we; mg_addr = MW'(ma); mg_wdata = wd;
        n = 0;
        do begin @(negedge clk); n++; end while (!mg_ack && n < 40);
        rd = mg_rdata;
        mg_req = 1'b0; mg_we = 1'b0;
    endtask

    // Window access on the half-size instance.
    task automatic do_hmg(input bit we, input int ma, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd);
        int n;
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_addr = MW'(ma); h_wdata = wd;
        n = 0;
        do begin @(negedge clk); n++; end while (!h_ack && n < 40);
        rd = h_rdata;
        h_req = 1'b0; h_we = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        int n, mism;
        for (int a = 0; a < (1 << AW); a++) ref_mem[a] = seed(a);
        for (int w = 0; w < 4; w++)
            for (int s = 0; s < 16; s++) begin
                m_v[w][s] = 1'b0; m_d[w][s] = 1'b0;
                m_tag[w][s] = '0; m_data[w][s] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset, first access misses.
        chk(!rd_valid && !mg_ack && !mem_req, "R1 idle outputs",
            int'({rd_valid, mg_ack, mem_req}), 0);
        do_read(16'h035, "R1 first read");

        // R2 / R3: every set, six tags over four ways, then re-reads.
        way_en = 4'hF;
        for (int t = 0; t < 6; t++)
            for (int s = 0; s < 16; s++) do_read(t * 16 + s, "R3 sweep");
        for (int t = 2; t < 6; t++)
            for (int s = 0; s < 16; s += 3) do_read(t * 16 + s, "R2 reread");

        // R3 / R4: preload way 3 only, then lock it and flood the rest.
        way_en = 4'b1000;
        for (int s = 0; s < 16; s++) do_read(20 * 16 + s, "R3 preload");
        for (int s = 0; s < 16; s++) begin
            do_mg(1'b0, 3 * 16 + s, '0, r, n);
            chk(r == seed(20 * 16 + s), "R3 preload landed in way 3", int'(r), int'(seed(20 * 16 + s)));
        end
        way_en = 4'b0111;
        for (int t = 30; t < 38; t++)
            for (int s = 0; s < 16; s++) do_read(t * 16 + s, "R4 flood");
        for (int s = 0; s < 16; s++) begin
            do_read(20 * 16 + s, "R4 locked line");
            chk(rd_hit == 1'b1, "R4 locked hit", int'(rd_hit), 1);
        end

        // R5: no allocation with the mask empty.
        way_en = 4'b0000;
        do_read(50 * 16 + 2, "R5 miss one");
        do_read(50 * 16 + 2, "R5 miss again");
        chk(rd_hit == 1'b0, "R5 still misses", int'(rd_hit), 0);
        do_read(20 * 16 + 2, "R5 locked still hits");

        // R7 / R8: fill the window linearly, read back with alias bits set.
        for (int l = 0; l < 64; l++) begin
            do_mg(1'b1, l, DW'(16'hA000 + l * 3), r, n);
            chk(n == 1, "R8 write ack", n, 1);
        end
        for (int l = 0; l < 64; l++) begin
            do_mg(1'b0, ((l % 16) ^ 5) * 64 + l, '0, r, n);
            chk(r == DW'(16'hA000 + l * 3), "R7 contiguous alias read", int'(r), int'(16'hA000 + l * 3));
        end

        // R8: window write tag becomes {alias, way}; a normal read hits it.
        do_mg(1'b1, 7 * 64 + 2 * 16 + 5, 16'hBEEF, r, n);
        do_read(16'h1E5, "R8 tag side effect");
        chk(rd_hit == 1'b1, "R8 window line hits", int'(rd_hit), 1);

        // R6: dirty window line is written back before the fill.
        way_en = 4'b0100;
        do_read(16'h705, "R6 dirty eviction");
        chk(mem[16'h1E5] == 16'hBEEF, "R6 write-back data", int'(mem[16'h1E5]), int'(16'hBEEF));

        // R10: read and window request in the same cycle.
        way_en = 4'hF;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 11'h705;
        mg_req = 1'b1; mg_we = 1'b0; mg_addr = 10'h003;
        @(negedge clk);
        chk(rd_valid == 1'b1, "R10 read first", int'(rd_valid), 1);
        chk(mg_ack == 1'b0, "R10 window stalled", int'(mg_ack), 0);
        chk(rd_data == seed(16'h705), "R10 read data", int'(rd_data), int'(seed(16'h705)));
        rd_req = 1'b0;
        @(negedge clk);
        chk(mg_ack == 1'b1, "R10 window one cycle later", int'(mg_ack), 1);
        chk(mg_rdata == m_data[0][3], "R10 window data", int'(mg_rdata), int'(m_data[0][3]));
        mg_req = 1'b0;

        // R9: half-size build backs only the lower half of each bank.
        do_hmg(1'b1, 1 * 16 + 1, 16'h1111, r);
        do_hmg(1'b1, 1 * 16 + 9, 16'h9999, r);
        do_hmg(1'b0, 1 * 16 + 1, '0, r);
        chk(r == 16'h1111, "R9 backed slot kept", int'(r), int'(16'h1111));
        do_hmg(1'b0, 1 * 16 + 9, '0, r);
        chk(r == 16'h0000, "R9 unbacked slot reads zero", int'(r), 0);

        // R6: all write-backs reached memory exactly as modelled.
        mism = 0;
        for (int a = 0; a < (1 << AW); a++) if (mem[a] != ref_mem[a]) mism++;
        chk(mism == 0, "R6 memory image", mism, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule